// File: doc/BRIEF.md
# Memory Tag Check Unit

This unit guards a small on-chip data memory with per-block version tags. Every 64-bit data address carries a 4-bit version tag in its top nibble. The memory keeps one stored tag for each 64-byte block. When tag checking applies to an access, the unit compares the two tags. Checking applies only when the per-task enable and the page's check-enable bit are both set, and only for data accesses. Loads, stores and instruction fetches arrive on one request port. The response is registered and appears one cycle after the request. It carries either data or a 2-bit fault code with the faulting address.

A mismatching load always produces a precise fault. A mismatching store also produces a precise fault when precise mode is on. With precise mode off, the store is reported as deferred instead. The program counter of the first deferred store is held in a pending register until software acknowledges it. A faulting store never changes the data memory.

A second port manages the tags:
- A set operation programs a block's tag. It is refused with a distinct fault code while the task enable is off. The reserved tag values 0x0 and 0xF raise a configuration error.
- A read operation returns a block's stored tag.
- A clear operation zeroes both the tag and the data of one block.

Top module: `mem_tag_check_unit`

## Requirements
- R1: After reset, every stored tag and every data word is zero, no deferred fault is pending, and `rsp_valid`, `fault_code`, `cfg_err` are 0.
- R2: The address tag is bits 63:60. It is compared with the stored tag of the 64-byte block selected by address bits [63-4:6] modulo the block count. Any byte offset inside a block uses that block's tag.
- R3: A data access is checked only when `task_chk_en` and `page_chk_en` are both 1. Otherwise a load returns data, a store writes, and no fault is reported.
- R4: An instruction fetch (`req_fetch`=1) is never checked and never faults. It returns the addressed word.
- R5: A checked load whose tag mismatches gives `fault_code`=1 (precise) and `fault_addr` equal to the request address, with `rsp_rdata`=0.
- R6: A checked store that mismatches while `precise_mode`=1 gives `fault_code`=1 with the address, and the data memory is left unchanged.
- R7: A checked store that mismatches while `precise_mode`=0 gives `fault_code`=2 (deferred) and leaves memory unchanged. If nothing is pending, it sets `dfr_pending` and latches `req_pc` into `dfr_pc`. A later mismatch does not overwrite the latched PC.
- R8: `dfr_pending` and `dfr_pc` hold until `dfr_ack` is 1 at a clock edge; `dfr_pending` is 0 after that edge.
- R9: A tag set (`tag_op`=0) while `task_chk_en`=0 gives `fault_code`=3 (tagging disabled), and the stored tag is not changed.
- R10: A tag set with value 0x0 or 0xF while enabled pulses `cfg_err` for one cycle, and the stored tag is not changed.
- R11: A block clear (`tag_op`=2) zeroes that block's stored tag and every data word in it, and leaves other blocks intact.
- R12: A tag read (`tag_op`=1) presents the block's stored tag on `tag_rdata` one cycle later.
- R13: Every request gives exactly one `rsp_valid` pulse one cycle later. `fault_code` is nonzero only in that response cycle, or in the cycle after a rejected tag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_fetch | input | 1 | Instruction fetch (read, never checked) |
| req_addr | input | 64 | Byte address with tag in bits 63:60 |
| req_wdata | input | 64 | Store data |
| req_pc | input | 64 | PC of the accessing instruction |
| page_chk_en | input | 1 | Page-level check enable from translation |
| task_chk_en | input | 1 | Per-task tagging enable |
| precise_mode | input | 1 | Stores report precise faults when 1 |
| tag_valid | input | 1 | Tag operation strobe |
| tag_op | input | 2 | 0 set, 1 read, 2 block clear, 3 no-op |
| tag_addr | input | 64 | Address selecting the block |
| tag_value | input | 4 | Tag to program |
| dfr_ack | input | 1 | Acknowledge of the pending deferred fault |
| rsp_valid | output | 1 | Access response valid |
| rsp_rdata | output | 64 | Load or fetch data (0 on fault) |
| fault_code | output | 2 | 0 none, 1 precise, 2 deferred, 3 tagging disabled |
| fault_addr | output | 64 | Faulting address for codes 1 and 3 |
| tag_rdata | output | 4 | Tag read result |
| cfg_err | output | 1 | Reserved tag value programmed |
| dfr_pending | output | 1 | Deferred fault awaiting acknowledge |
| dfr_pc | output | 64 | PC of the first deferred mismatching store |

## Verification
The bench places a correct tag at the last byte of a block and a wrong tag at the first byte of the next block. A design that slices the block index from the wrong bits either misses that fault or flags a good access. It sends a second deferred store with a different PC while one is pending. A design that overwrites the latch then shows the later PC. After each precise or deferred store, it reads the word back with the right tag, which exposes any design that lets a faulting store reach memory. It also drives mismatching tags with each enable off, as fetches, and as reserved tag writes. These catch a single-enable check, a checked fetch, and tag updates that should have been refused.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int ADDR_W  = 64;
  localparam int TAG_W   = 4;
  localparam int TAG_LSB = ADDR_W - TAG_W;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_PRECISE  = 2'd1,
    FLT_DEFERRED = 2'd2,
    FLT_TAGOFF   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    TOP_SET   = 2'd0,
    TOP_READ  = 2'd1,
    TOP_CLEAR = 2'd2,
    TOP_NOP   = 2'd3
  } tag_op_e;

  // Version tag carried in the top nibble of an address.
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return TAG_W'(a >> TAG_LSB);
  endfunction

  // Address shifted down to a field; callers size-cast to the field width.
  function automatic logic [ADDR_W-1:0] addr_field(input logic [ADDR_W-1:0] a, input int lsb);
    return a >> lsb;
  endfunction

  function automatic logic tag_reserved(input logic [TAG_W-1:0] t);
    return (t == '0) || (t == '1);
  endfunction
endpackage

// File: rtl/mtc_tag_store.sv
module mtc_tag_store import mtc_pkg::*; #(
  parameter int NUM_BLKS = 8,
  parameter int BLK_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_val,
  input  logic             clr_en,
  input  logic [BLK_W-1:0] clr_idx,
  input  logic [BLK_W-1:0] rd_a_idx,
  output logic [TAG_W-1:0] rd_a_tag,
  input  logic [BLK_W-1:0] rd_b_idx,
  output logic [TAG_W-1:0] rd_b_tag
);
  logic [TAG_W-1:0] tags [NUM_BLKS];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BLKS; b++) begin
      if (!rst_n)
        tags[b] <= '0;
      else if (clr_en && (int'(clr_idx) == b))
        tags[b] <= '0;
      else if (set_en && (int'(set_idx) == b))
        tags[b] <= set_val;
    end
  end

  assign rd_a_tag = tags[rd_a_idx];
  assign rd_b_tag = tags[rd_b_idx];
endmodule

// File: rtl/mtc_data_mem.sv
module mtc_data_mem #(
  parameter int DATA_W    = 64,
  parameter int NUM_WORDS = 64,
  parameter int WIDX_W    = 6,
  parameter int WPB       = 8,
  parameter int BLK_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WIDX_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_en,
  input  logic [BLK_W-1:0]  clr_blk,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] words [NUM_WORDS];

  always_ff @(posedge clk) begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (!rst_n)
        words[w] <= '0;
      else if (clr_en && ((w / WPB) == int'(clr_blk)))
        words[w] <= '0;
      else if (we && (int'(widx) == w))
        words[w] <= wdata;
    end
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/mtc_classify.sv
module mtc_classify import mtc_pkg::*; (
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_fetch,
  input  logic             task_en,
  input  logic             page_en,
  input  logic             precise_mode,
  input  logic [TAG_W-1:0] addr_tag,
  input  logic [TAG_W-1:0] blk_tag,
  output logic             chk_active,
  output logic             mismatch,
  output logic             precise_flt,
  output logic             deferred_flt
);
  always_comb begin
    chk_active   = req_valid && !req_fetch && task_en && page_en;
    mismatch     = chk_active && (addr_tag != blk_tag);
    precise_flt  = mismatch && (!req_write || precise_mode);
    deferred_flt = mismatch && req_write && !precise_mode;
  end
endmodule

// File: rtl/mtc_defer_latch.sv
module mtc_defer_latch #(
  parameter int PC_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [PC_W-1:0] pc_in,
  input  logic            ack,
  output logic            pending,
  output logic [PC_W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      pc_q    <= '0;
    end else if (capture && (!pending || ack)) begin
      pending <= 1'b1;
      pc_q    <= pc_in;
    end else if (ack) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_tag_check_unit.sv
module mem_tag_check_unit import mtc_pkg::*; #(
  parameter int DATA_W    = 64,
  parameter int BLK_BYTES = 64,
  parameter int NUM_BLKS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [63:0]       req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [63:0]       req_pc,
  input  logic              page_chk_en,
  input  logic              task_chk_en,
  input  logic              precise_mode,
  input  logic              tag_valid,
  input  logic [1:0]        tag_op,
  input  logic [63:0]       tag_addr,
  input  logic [3:0]        tag_value,
  input  logic              dfr_ack,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        fault_code,
  output logic [63:0]       fault_addr,
  output logic [3:0]        tag_rdata,
  output logic              cfg_err,
  output logic              dfr_pending,
  output logic [63:0]       dfr_pc
);
  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam int BYTE_W    = $clog2(BYTES_PER_WORD);
  localparam int OFS_W     = $clog2(BLK_BYTES);
  localparam int WPB       = BLK_BYTES / BYTES_PER_WORD;
  localparam int BLK_W     = $clog2(NUM_BLKS);
  localparam int WIDX_W    = BLK_W + $clog2(WPB);
  localparam int NUM_WORDS = NUM_BLKS * WPB;

  // Address decode
  logic [BLK_W-1:0]  acc_blk, op_blk;
  logic [WIDX_W-1:0] acc_widx;
  logic [TAG_W-1:0]  acc_tag, blk_tag, op_tag_rd;
  assign acc_blk  = BLK_W'(addr_field(req_addr, OFS_W));
  assign acc_widx = WIDX_W'(addr_field(req_addr, BYTE_W));
  assign acc_tag  = tag_of(req_addr);
  assign op_blk   = BLK_W'(addr_field(tag_addr, OFS_W));

  // Tag-port decode (named events for the checker)
  logic set_req_w, set_reject_w, set_bad_w, set_ok_w, clr_w, rd_w;
  assign set_req_w    = tag_valid && (tag_op == TOP_SET);
  assign set_reject_w = set_req_w && !task_chk_en;
  assign set_bad_w    = set_req_w && task_chk_en && tag_reserved(tag_value);
  assign set_ok_w     = set_req_w && task_chk_en && !tag_reserved(tag_value);
  assign clr_w        = tag_valid && (tag_op == TOP_CLEAR);
  assign rd_w         = tag_valid && (tag_op == TOP_READ);

  mtc_tag_store #(.NUM_BLKS(NUM_BLKS), .BLK_W(BLK_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_ok_w), .set_idx(op_blk), .set_val(tag_value),
    .clr_en(clr_w), .clr_idx(op_blk),
    .rd_a_idx(acc_blk), .rd_a_tag(blk_tag),
    .rd_b_idx(op_blk), .rd_b_tag(op_tag_rd)
  );

  // Access classification
  logic chk_active_w, mismatch_w, precise_w, deferred_w;
  mtc_classify u_cls (
    .req_valid(req_valid), .req_write(req_write), .req_fetch(req_fetch),
    .task_en(task_chk_en), .page_en(page_chk_en), .precise_mode(precise_mode),
    .addr_tag(acc_tag), .blk_tag(blk_tag),
    .chk_active(chk_active_w), .mismatch(mismatch_w),
    .precise_flt(precise_w), .deferred_flt(deferred_w)
  );

  logic mem_we_w, is_read_w;
  logic [DATA_W-1:0] mem_rd;
  assign mem_we_w  = req_valid && req_write && !req_fetch && !mismatch_w;
  assign is_read_w = req_valid && (!req_write || req_fetch);

  mtc_data_mem #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W),
                 .WPB(WPB), .BLK_W(BLK_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we_w), .widx(acc_widx), .wdata(req_wdata),
    .clr_en(clr_w), .clr_blk(op_blk),
    .rd_idx(acc_widx), .rd_data(mem_rd)
  );

  mtc_defer_latch #(.PC_W(64)) u_dfr (
    .clk(clk), .rst_n(rst_n),
    .capture(deferred_w), .pc_in(req_pc), .ack(dfr_ack),
    .pending(dfr_pending), .pc_q(dfr_pc)
  );

  // Registered response
  fault_e fault_nx;
  always_comb begin
    if (precise_w)         fault_nx = FLT_PRECISE;
    else if (set_reject_w) fault_nx = FLT_TAGOFF;
    else if (deferred_w)   fault_nx = FLT_DEFERRED;
    else                   fault_nx = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      fault_code <= FLT_NONE;
      fault_addr <= '0;
      tag_rdata  <= '0;
      cfg_err    <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_rdata  <= (is_read_w && !precise_w) ? mem_rd : '0;
      fault_code <= fault_nx;
      fault_addr <= precise_w ? req_addr : (set_reject_w ? tag_addr : '0);
      cfg_err    <= set_bad_w;
      if (rd_w) tag_rdata <= op_tag_rd;
    end
  end
endmodule

// File: rtl/mem_tag_check_unit_sva.sv
module mem_tag_check_unit_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_fetch,
  input logic [63:0] req_addr,
  input logic [63:0] req_pc,
  input logic        task_chk_en,
  input logic        page_chk_en,
  input logic        precise_mode,
  input logic        tag_valid,
  input logic [1:0]  tag_op,
  input logic [3:0]  tag_value,
  input logic        dfr_ack,
  input logic        rsp_valid,
  input logic [1:0]  fault_code,
  input logic [63:0] fault_addr,
  input logic        cfg_err,
  input logic        dfr_pending,
  input logic [63:0] dfr_pc,
  input logic        mismatch
);
  // R3: with either enable off, no access fault appears
  p_unchecked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(task_chk_en && page_chk_en) && !tag_valid) |=> (fault_code == 2'd0));

  // R4: fetches never fault
  p_fetch_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch && !tag_valid) |=> (fault_code == 2'd0));

  // R5: mismatching load -> precise with its address
  p_load_precise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && mismatch) |=> (fault_code == 2'd1 && fault_addr == $past(req_addr)));

  // R7: first deferred mismatch latches its PC
  p_defer_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && mismatch && !precise_mode && !dfr_pending)
      |=> (dfr_pending && dfr_pc == $past(req_pc)));

  // R8: pending state holds without acknowledge
  p_pending_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dfr_pending && !dfr_ack) |=> (dfr_pending && $stable(dfr_pc)));

  // R8: acknowledge without new deferred store clears pending
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dfr_ack && !(req_valid && req_write && mismatch && !precise_mode)) |=> !dfr_pending);

  // R9: tag set while disabled -> tagging-disabled code
  p_tagoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && tag_op == 2'd0 && !task_chk_en && !req_valid) |=> (fault_code == 2'd3));

  // R10: reserved tag value flags a configuration error
  p_cfgerr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && tag_op == 2'd0 && task_chk_en && (tag_value == 4'h0 || tag_value == 4'hF))
      |=> cfg_err);

  // R13: exactly one response per request
  p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !tag_valid) |=> (!rsp_valid && fault_code == 2'd0));
endmodule

bind mem_tag_check_unit mem_tag_check_unit_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_fetch(req_fetch), .req_addr(req_addr), .req_pc(req_pc),
  .task_chk_en(task_chk_en), .page_chk_en(page_chk_en), .precise_mode(precise_mode),
  .tag_valid(tag_valid), .tag_op(tag_op), .tag_value(tag_value), .dfr_ack(dfr_ack),
  .rsp_valid(rsp_valid), .fault_code(fault_code), .fault_addr(fault_addr),
  .cfg_err(cfg_err), .dfr_pending(dfr_pending), .dfr_pc(dfr_pc),
  .mismatch(mismatch_w)
);

// File: tb/mem_tag_check_unit_test.sv
module mem_tag_check_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_fetch;
  logic [63:0] req_addr, req_wdata, req_pc;
  logic        page_chk_en, task_chk_en, precise_mode;
  logic        tag_valid;
  logic [1:0]  tag_op;
  logic [63:0] tag_addr;
  logic [3:0]  tag_value;
  logic        dfr_ack;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic [1:0]  fault_code;
  logic [63:0] fault_addr;
  logic [3:0]  tag_rdata;
  logic        cfg_err, dfr_pending;
  logic [63:0] dfr_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  mem_tag_check_unit uut (.*);

  function automatic logic [63:0] mk_addr(input logic [3:0] t, input int blk, input int w, input int b);
    return {t, 60'd0} | 64'(blk * 64) | 64'(w * 8) | 64'(b);
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic fe, input logic [63:0] a,
                        input logic [63:0] wd, input logic [63:0] pc);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_fetch = fe;
    req_addr = a; req_wdata = wd; req_pc = pc;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0;
  endtask

  task automatic tagop(input logic [1:0] op, input logic [63:0] a, input logic [3:0] v);
    @(negedge clk);
    tag_valid = 1'b1; tag_op = op; tag_addr = a; tag_value = v;
    @(posedge clk); #1;
    tag_valid = 1'b0; tag_op = 2'd3;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid", 64'(rsp_valid), 0);
    chk("R1 fault_code", 64'(fault_code), 0);
    chk("R1 cfg_err", 64'(cfg_err), 0);
    chk("R1 pending", 64'(dfr_pending), 0);
    tagop(2'd1, mk_addr(4'h0, 3, 0, 0), 4'h0);
    chk("R1 tag zero", 64'(tag_rdata), 0);
    access(1'b0, 1'b0, mk_addr(4'h0, 5, 2, 0), 0, 0);
    chk("R1 tag0 access ok", 64'(fault_code), 0);
    chk("R1 data zero", rsp_rdata, 0);
  endtask

  task automatic t_set_read();
    tagop(2'd0, mk_addr(4'h0, 2, 0, 0), 4'hA);
    chk("R12 set no fault", 64'(fault_code), 0);
    tagop(2'd1, mk_addr(4'h0, 2, 5, 3), 4'h0);
    chk("R12 tag read", 64'(tag_rdata), 64'hA);
  endtask

  task automatic t_match();
    access(1'b1, 1'b0, mk_addr(4'hA, 2, 0, 0), 64'h1111, 64'h10);
    chk("R2 matched store", 64'(fault_code), 0);
    chk("R13 store rsp", 64'(rsp_valid), 1);
    access(1'b0, 1'b0, mk_addr(4'hA, 2, 0, 0), 0, 64'h14);
    chk("R2 matched load", rsp_rdata, 64'h1111);
    access(1'b0, 1'b0, mk_addr(4'hA, 2, 7, 7), 0, 0);
    chk("R2 last byte of block", 64'(fault_code), 0);
    access(1'b0, 1'b0, mk_addr(4'hA, 3, 0, 0), 0, 0);
    chk("R2 next block faults", 64'(fault_code), 1);
  endtask

  task automatic t_load_mismatch();
    access(1'b0, 1'b0, mk_addr(4'h5, 2, 0, 4), 0, 64'h20);
    chk("R5 code", 64'(fault_code), 1);
    chk("R5 addr", fault_addr, mk_addr(4'h5, 2, 0, 4));
    chk("R5 rdata", rsp_rdata, 0);
    idle();
    chk("R13 fault gone", 64'(fault_code), 0);
    chk("R13 rsp gone", 64'(rsp_valid), 0);
  endtask

  task automatic t_enables();
    page_chk_en = 1'b0;
    access(1'b0, 1'b0, mk_addr(4'h5, 2, 0, 0), 0, 0);
    chk("R3 page off no fault", 64'(fault_code), 0);
    chk("R3 page off data", rsp_rdata, 64'h1111);
    access(1'b1, 1'b0, mk_addr(4'h5, 2, 1, 0), 64'h2222, 0);
    chk("R3 page off store", 64'(fault_code), 0);
    page_chk_en = 1'b1; task_chk_en = 1'b0;
    access(1'b0, 1'b0, mk_addr(4'h6, 2, 1, 0), 0, 0);
    chk("R3 task off no fault", 64'(fault_code), 0);
    chk("R3 unchecked store landed", rsp_rdata, 64'h2222);
    task_chk_en = 1'b1;
  endtask

  task automatic t_fetch();
    access(1'b0, 1'b1, mk_addr(4'h7, 2, 0, 0), 0, 0);
    chk("R4 fetch no fault", 64'(fault_code), 0);
    chk("R4 fetch data", rsp_rdata, 64'h1111);
  endtask

  task automatic t_store_precise();
    precise_mode = 1'b1;
    access(1'b1, 1'b0, mk_addr(4'h5, 2, 0, 0), 64'hDEAD, 64'h30);
    chk("R6 code", 64'(fault_code), 1);
    chk("R6 addr", fault_addr, mk_addr(4'h5, 2, 0, 0));
    chk("R6 no pending", 64'(dfr_pending), 0);
    access(1'b0, 1'b0, mk_addr(4'hA, 2, 0, 0), 0, 0);
    chk("R6 memory unchanged", rsp_rdata, 64'h1111);
    precise_mode = 1'b0;
  endtask

  task automatic t_store_deferred();
    access(1'b1, 1'b0, mk_addr(4'h5, 2, 0, 0), 64'hBEEF, 64'h1000);
    chk("R7 code", 64'(fault_code), 2);
    chk("R7 pending", 64'(dfr_pending), 1);
    chk("R7 pc", dfr_pc, 64'h1000);
    access(1'b1, 1'b0, mk_addr(4'h9, 2, 1, 0), 64'hBEEF, 64'h2000);
    chk("R7 second code", 64'(fault_code), 2);
    chk("R7 first pc kept", dfr_pc, 64'h1000);
    access(1'b0, 1'b0, mk_addr(4'hA, 2, 0, 0), 0, 0);
    chk("R7 memory unchanged", rsp_rdata, 64'h1111);
    repeat (3) idle();
    chk("R8 still pending", 64'(dfr_pending), 1);
    @(negedge clk); dfr_ack = 1'b1;
    @(posedge clk); #1; dfr_ack = 1'b0;
    chk("R8 ack clears", 64'(dfr_pending), 0);
    access(1'b1, 1'b0, mk_addr(4'h3, 2, 0, 0), 64'hBEEF, 64'h3000);
    chk("R8 relatch after ack", dfr_pc, 64'h3000);
    @(negedge clk); dfr_ack = 1'b1;
    @(posedge clk); #1; dfr_ack = 1'b0;
  endtask

  task automatic t_tagoff();
    task_chk_en = 1'b0;
    tagop(2'd0, mk_addr(4'h0, 2, 0, 0), 4'h7);
    chk("R9 code", 64'(fault_code), 3);
    chk("R9 addr", fault_addr, mk_addr(4'h0, 2, 0, 0));
    task_chk_en = 1'b1;
    tagop(2'd1, mk_addr(4'h0, 2, 0, 0), 4'h0);
    chk("R9 tag kept", 64'(tag_rdata), 64'hA);
  endtask

  task automatic t_reserved();
    tagop(2'd0, mk_addr(4'h0, 2, 0, 0), 4'h0);
    chk("R10 zero cfg_err", 64'(cfg_err), 1);
    idle();
    chk("R10 cfg_err one cycle", 64'(cfg_err), 0);
    tagop(2'd0, mk_addr(4'h0, 2, 0, 0), 4'hF);
    chk("R10 F cfg_err", 64'(cfg_err), 1);
    tagop(2'd1, mk_addr(4'h0, 2, 0, 0), 4'h0);
    chk("R10 tag kept", 64'(tag_rdata), 64'hA);
  endtask

  task automatic t_clear();
    access(1'b1, 1'b0, mk_addr(4'h0, 1, 0, 0), 64'h3333, 0);
    tagop(2'd2, mk_addr(4'h0, 2, 3, 0), 4'h0);
    tagop(2'd1, mk_addr(4'h0, 2, 0, 0), 4'h0);
    chk("R11 tag cleared", 64'(tag_rdata), 0);
    access(1'b0, 1'b0, mk_addr(4'h0, 2, 0, 0), 0, 0);
    chk("R11 word0 cleared", rsp_rdata, 0);
    chk("R11 tag0 now matches", 64'(fault_code), 0);
    access(1'b0, 1'b0, mk_addr(4'h0, 2, 1, 0), 0, 0);
    chk("R11 word1 cleared", rsp_rdata, 0);
    access(1'b0, 1'b0, mk_addr(4'h0, 1, 0, 0), 0, 0);
    chk("R11 other block kept", rsp_rdata, 64'h3333);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_fetch = 0;
    req_addr = 0; req_wdata = 0; req_pc = 0;
    page_chk_en = 1; task_chk_en = 1; precise_mode = 0;
    tag_valid = 0; tag_op = 2'd3; tag_addr = 0; tag_value = 0; dfr_ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_set_read();
    t_match();
    t_load_mismatch();
    t_enables();
    t_fetch();
    t_store_precise();
    t_store_deferred();
    t_tagoff();
    t_reserved();
    t_clear();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule